// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Master

This block drives a three-wire serial EEPROM that uses a select line, a serial clock, a data-out line and a data-in line. It carries out one 16-bit word read or one 16-bit word write for each host request. The host pulses `start` together with an operation select, a byte offset and, for a write, the data word. The block then frames the device commands bit by bit and pulses `done` once the serial lines are back at rest.

A write needs only one request. The block first sends the enable command, then the write command with the address, followed by the data. It then briefly drops and re-asserts select and watches the device's data line until the device reports that programming has finished. If the device never reports ready, the block gives up after a bounded number of polls and raises `timeout`. In either case it closes the sequence with the disable command. The serial clock rate, the polling interval and the poll limit are all parameters.

Top module: `uwire_eeprom_master`

## Requirements
- R1: After reset, `ee_cs`, `ee_sck`, `ee_sdo`, `done`, `timeout` and `rdata` are all 0.
- R2: Every command is CMD_BITS = ADDR_BITS+3 bits long and is sent most significant bit first. It is a 3-bit opcode followed by the word address, which is `byte_off[ADDR_BITS:1]` (the byte offset's bit 0 is dropped). The opcodes are: read 3'b110 + address; write 3'b101 + address; enable 3'b100 with the address field's two upper bits 2'b11 and the rest 0; disable 3'b100 with an all-zero address field.
- R3: `ee_sck` is only high while `ee_cs` is high, and `ee_sdo` never changes while `ee_sck` is high. Each clock high phase and each clock low phase inside a frame lasts exactly HALF_DIV system clocks.
- R4: While `ee_cs` is low, `ee_sck` and `ee_sdo` are low. Every rise of `ee_cs` comes after at least HALF_DIV cycles with `ee_cs` low.
- R5: A read is one select frame: the read command, then 16 clock pulses with `ee_sdo` low. `ee_sdi` is sampled at the end of each high phase, and the first sample becomes `rdata[15]`.
- R6: A write sends the enable command in its own frame. It then sends the write command followed at once by the 16 data bits (MSB first) in a single frame. After that, `ee_cs` goes low for HALF_DIV cycles and rises again for the ready wait.
- R7: During the ready wait no clock pulses are sent. `ee_sdi` is sampled every POLL_CYCLES cycles, and a high sample ends the wait without setting `timeout`.
- R8: If MAX_POLLS consecutive samples are low, the wait ends after MAX_POLLS*POLL_CYCLES cycles and `timeout` is set. `timeout` holds until the next accepted `start`, which clears it.
- R9: Every ready wait, whether it succeeds or times out, is followed by the disable command in its own frame, and then all serial lines are low.
- R10: `done` is a single-cycle pulse. It occurs HALF_DIV cycles after the last falling edge of `ee_sck`, with all serial lines low.
- R11: A `start` pulse that arrives while a transaction is in progress is ignored: it causes no extra frame and no extra `done`.
- R12: `rdata` changes only in the cycle `done` is high after a read. A write leaves `rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request strobe, accepted only when idle |
| op_write | input | 1 | 1 = word write, 0 = word read; sampled with `start` |
| byte_off | input | ADDR_BITS+1 | Byte offset; the word address is the offset divided by two |
| wdata | input | 16 | Word to write; sampled with `start` |
| rdata | output | 16 | Last word read |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | Ready wait of the last write ran out |
| ee_cs | output | 1 | Device select, active high |
| ee_sck | output | 1 | Serial clock |
| ee_sdo | output | 1 | Serial data to the device |
| ee_sdi | input | 1 | Serial data from the device, also used as the ready indicator |

## Verification
The assertions check the pin rules on every cycle: the clock only pulses under select, data out is stable while the clock is high, data out is quiet when select is low, the clock high width is at least one half period, `done` lasts a single cycle with the lines at rest, and `rdata` stays stable outside completion. Several things can only be shown by the bench's scenarios, which run against a behavioural device model: the exact command bits and frame boundaries of both operations, that a written word reads back correctly, the order in which bits arrive in `rdata`, the poll count before a timeout, that a disable command follows a failed wait, and that a start strobe arriving mid-transaction is dropped.

// File: rtl/uwe_pkg.sv
package uwe_pkg;

    localparam int WORD_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GAP,
        ST_LO,
        ST_HI,
        ST_DESEL,
        ST_POLL,
        ST_TAIL
    } st_e;

    typedef enum logic [2:0] {
        SQ_WREN,
        SQ_WCMD,
        SQ_WDATA,
        SQ_WDS,
        SQ_RCMD,
        SQ_RDATA
    } seq_e;

    localparam logic [2:0] OPC_READ  = 3'b110;
    localparam logic [2:0] OPC_WRITE = 3'b101;
    localparam logic [2:0] OPC_MISC  = 3'b100;

endpackage

// File: rtl/uwe_halftick.sv
module uwe_halftick #(
    parameter int HALF = 132
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = (HALF < 2) ? 1 : $clog2(HALF);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          wrap;

    assign wrap = (cnt_q == CW'(HALF - 1));
    assign tick = !clr && wrap;

    always_comb begin
        if (clr || wrap) cnt_d = '0;
        else             cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/uwe_poll_timer.sv
module uwe_poll_timer #(
    parameter int INTERVAL  = 330,
    parameter int MAX_POLLS = 20000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic strobe,
    output logic last
);
    localparam int IW = (INTERVAL < 2) ? 1 : $clog2(INTERVAL);
    localparam int NW = $clog2(MAX_POLLS + 1);

    logic [IW-1:0] ivl_d, ivl_q;
    logic [NW-1:0] num_d, num_q;

    assign strobe = en && (ivl_q == IW'(INTERVAL - 1));
    assign last   = (num_q == NW'(MAX_POLLS - 1));

    always_comb begin
        ivl_d = ivl_q;
        num_d = num_q;
        if (!en) begin
            ivl_d = '0;
            num_d = '0;
        end else if (strobe) begin
            ivl_d = '0;
            if (!last) num_d = num_q + 1'b1;
        end else begin
            ivl_d = ivl_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ivl_q <= '0;
            num_q <= '0;
        end else begin
            ivl_q <= ivl_d;
            num_q <= num_d;
        end
    end
endmodule

// File: rtl/uwe_cmd_gen.sv
module uwe_cmd_gen
    import uwe_pkg::*;
#(
    parameter int ADDR_BITS = 8
) (
    input  seq_e                   kind,
    input  logic [ADDR_BITS-1:0]   waddr,
    output logic [ADDR_BITS+2:0]   cmd
);
    localparam logic [ADDR_BITS-1:0] ENA_FIELD = ADDR_BITS'(2'b11) << (ADDR_BITS - 2);

    always_comb begin
        case (kind)
            SQ_WREN: cmd = {OPC_MISC, ENA_FIELD};
            SQ_WDS:  cmd = {OPC_MISC, {ADDR_BITS{1'b0}}};
            SQ_WCMD: cmd = {OPC_WRITE, waddr};
            default: cmd = {OPC_READ, waddr};
        endcase
    end
endmodule

// File: rtl/uwire_eeprom_master.sv
module uwire_eeprom_master
    import uwe_pkg::*;
#(
    parameter int HALF_DIV    = 132,
    parameter int ADDR_BITS   = 8,
    parameter int POLL_CYCLES = 330,
    parameter int MAX_POLLS   = 20000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  op_write,
    input  logic [ADDR_BITS:0]    byte_off,
    input  logic [WORD_W-1:0]     wdata,
    output logic [WORD_W-1:0]     rdata,
    output logic                  done,
    output logic                  timeout,
    output logic                  ee_cs,
    output logic                  ee_sck,
    output logic                  ee_sdo,
    input  logic                  ee_sdi
);
    localparam int CMD_BITS = ADDR_BITS + 3;
    localparam int SH_W     = (CMD_BITS > WORD_W) ? CMD_BITS : WORD_W;
    localparam int CNT_W    = $clog2(SH_W);

    typedef struct packed {
        st_e                  st;
        seq_e                 seq;
        logic [SH_W-1:0]      shreg;
        logic [CNT_W-1:0]     bitcnt;
        logic [WORD_W-1:0]    rd;
        logic [WORD_W-1:0]    rdata;
        logic [WORD_W-1:0]    wdata;
        logic [ADDR_BITS-1:0] waddr;
        logic                 tmo;
        logic                 done;
        logic                 cs;
        logic                 sck;
        logic                 sdo;
    } regs_t;

    regs_t r_d, r_q;

    logic                 tick;
    logic                 poll_strobe;
    logic                 poll_last;
    seq_e                 nxt_kind;
    logic [ADDR_BITS-1:0] nxt_addr;
    logic [CMD_BITS-1:0]  cmd;
    logic [SH_W-1:0]      cmd_load;
    logic [SH_W-1:0]      data_load;
    logic                 unused_byte_lsb;

    assign unused_byte_lsb = byte_off[0];

    uwe_halftick #(.HALF(HALF_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   ((r_q.st == ST_IDLE) || (r_q.st == ST_POLL)),
        .tick  (tick)
    );

    uwe_poll_timer #(.INTERVAL(POLL_CYCLES), .MAX_POLLS(MAX_POLLS)) u_poll (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (r_q.st == ST_POLL),
        .strobe (poll_strobe),
        .last   (poll_last)
    );

    // Which command the next frame will carry, picked from the registered state
    always_comb begin
        nxt_addr = r_q.waddr;
        if (r_q.st == ST_IDLE) begin
            nxt_kind = op_write ? SQ_WREN : SQ_RCMD;
            nxt_addr = byte_off[ADDR_BITS:1];
        end else if (r_q.st == ST_POLL) begin
            nxt_kind = SQ_WDS;
        end else if (r_q.seq == SQ_WREN) begin
            nxt_kind = SQ_WCMD;
        end else begin
            nxt_kind = SQ_RCMD;
        end
    end

    uwe_cmd_gen #(.ADDR_BITS(ADDR_BITS)) u_cmd (
        .kind  (nxt_kind),
        .waddr (nxt_addr),
        .cmd   (cmd)
    );

    assign cmd_load  = SH_W'(cmd) << (SH_W - CMD_BITS);
    assign data_load = SH_W'(r_q.wdata) << (SH_W - WORD_W);

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.seq    = op_write ? SQ_WREN : SQ_RCMD;
                    r_d.waddr  = byte_off[ADDR_BITS:1];
                    r_d.wdata  = wdata;
                    r_d.tmo    = 1'b0;
                    r_d.shreg  = cmd_load;
                    r_d.bitcnt = CNT_W'(CMD_BITS - 1);
                    r_d.st     = ST_GAP;
                end
            end
            ST_GAP: if (tick) r_d.st = ST_LO;
            ST_LO:  if (tick) r_d.st = ST_HI;
            ST_HI: begin
                if (tick) begin
                    if (r_q.seq == SQ_RDATA) r_d.rd = {r_q.rd[WORD_W-2:0], ee_sdi};
                    r_d.shreg = r_q.shreg << 1;
                    if (r_q.bitcnt != '0) begin
                        r_d.bitcnt = r_q.bitcnt - 1'b1;
                        r_d.st     = ST_LO;
                    end else begin
                        case (r_q.seq)
                            SQ_WREN: begin
                                r_d.seq    = SQ_WCMD;
                                r_d.shreg  = cmd_load;
                                r_d.bitcnt = CNT_W'(CMD_BITS - 1);
                                r_d.st     = ST_GAP;
                            end
                            SQ_WCMD: begin
                                r_d.seq    = SQ_WDATA;
                                r_d.shreg  = data_load;
                                r_d.bitcnt = CNT_W'(WORD_W - 1);
                                r_d.st     = ST_LO;
                            end
                            SQ_WDATA: r_d.st = ST_DESEL;
                            SQ_RCMD: begin
                                r_d.seq    = SQ_RDATA;
                                r_d.bitcnt = CNT_W'(WORD_W - 1);
                                r_d.st     = ST_LO;
                            end
                            default: r_d.st = ST_TAIL;
                        endcase
                    end
                end
            end
            ST_DESEL: if (tick) r_d.st = ST_POLL;
            ST_POLL: begin
                if (poll_strobe && (ee_sdi || poll_last)) begin
                    r_d.tmo    = !ee_sdi;
                    r_d.seq    = SQ_WDS;
                    r_d.shreg  = cmd_load;
                    r_d.bitcnt = CNT_W'(CMD_BITS - 1);
                    r_d.st     = ST_GAP;
                end
            end
            ST_TAIL: begin
                if (tick) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                    if (r_q.seq == SQ_RDATA) r_d.rdata = r_q.rd;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase

        // Registered pin values follow the next state
        r_d.cs  = (r_d.st == ST_LO) || (r_d.st == ST_HI) || (r_d.st == ST_POLL);
        r_d.sck = (r_d.st == ST_HI);
        r_d.sdo = ((r_d.st == ST_LO) || (r_d.st == ST_HI)) &&
                  (r_d.seq != SQ_RDATA) && r_d.shreg[SH_W-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.st     <= ST_IDLE;
            r_q.seq    <= SQ_RCMD;
        end else begin
            r_q <= r_d;
        end
    end

    assign rdata   = r_q.rdata;
    assign done    = r_q.done;
    assign timeout = r_q.tmo;
    assign ee_cs   = r_q.cs;
    assign ee_sck  = r_q.sck;
    assign ee_sdo  = r_q.sdo;
endmodule

// File: rtl/uwe_props.sv
module uwe_props #(
    parameter int HALF = 132
) (
    input logic        clk,
    input logic        rst_n,
    input logic        done,
    input logic [15:0] rdata,
    input logic        cs,
    input logic        sck,
    input logic        sdo
);
    int hi_len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   hi_len_q <= 0;
        else if (sck) hi_len_q <= hi_len_q + 1;
        else          hi_len_q <= 0;
    end

    AST_CLK_UNDER_SEL:  assert property (@(posedge clk) disable iff (!rst_n) sck |-> cs);                   // R3
    AST_SDO_HELD_HIGH:  assert property (@(posedge clk) disable iff (!rst_n) sck |-> $stable(sdo));         // R3
    AST_HIGH_WIDTH:     assert property (@(posedge clk) disable iff (!rst_n) $fell(sck) |-> hi_len_q >= HALF); // R3
    AST_QUIET_UNSEL:    assert property (@(posedge clk) disable iff (!rst_n) !cs |-> !sdo);                  // R4
    AST_DONE_SINGLE:    assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);                // R10
    AST_DONE_AT_REST:   assert property (@(posedge clk) disable iff (!rst_n) done |-> (!cs && !sck && !sdo)); // R10
    AST_RDATA_HELD:     assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(rdata));       // R12
endmodule

bind uwire_eeprom_master uwe_props #(.HALF(HALF_DIV)) u_props (
    .clk   (clk),
    .rst_n (rst_n),
    .done  (done),
    .rdata (rdata),
    .cs    (ee_cs),
    .sck   (ee_sck),
    .sdo   (ee_sdo)
);

// File: tb/uwire_eeprom_master_tb.sv
module uwire_eeprom_master_tb;
    localparam int HALF = 3;
    localparam int AB   = 8;
    localparam int PC   = 5;
    localparam int MP   = 4;
    localparam int CB   = AB + 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          op_write = 1'b0;
    logic [AB:0]   byte_off = '0;
    logic [15:0]   wdata = '0;
    logic [15:0]   rdata;
    logic          done, timeout, ee_cs, ee_sck, ee_sdo;
    logic          ee_sdi = 1'b0;

    always #10 clk = ~clk;

    uwire_eeprom_master #(
        .HALF_DIV(HALF), .ADDR_BITS(AB), .POLL_CYCLES(PC), .MAX_POLLS(MP)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_write(op_write),
        .byte_off(byte_off), .wdata(wdata), .rdata(rdata), .done(done),
        .timeout(timeout), .ee_cs(ee_cs), .ee_sck(ee_sck), .ee_sdo(ee_sdo),
        .ee_sdi(ee_sdi)
    );

    int  n_chk = 0;
    int  n_bad = 0;
    bit  finished = 0;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    // Behavioural device model and pin-rule reference
    logic [15:0] mem [256];
    bit          wen = 0, pend = 0, rd_mode = 0;
    int          nbits = 0, ready_delay = 0, cs_hi_cyc = 0, poll_len_last = 0;
    int          hi_run = 0, lo_run = 0, cslo_run = 100, done_cnt = 0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] fval = '0;
    longint      cyc = 0, last_fall = 0;
    logic        prev_cs = 0, prev_sck = 0, prev_sdo = 0, prev_done = 0;
    int          flen_q[$];
    logic [31:0] fval_q[$];

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (!ee_cs) chk(!ee_sck && !ee_sdo, "R4", "lines active without select", {ee_sck, ee_sdo}, 0);
            if (ee_sck) chk(ee_sdo == prev_sdo, "R3", "data moved while clock high", ee_sdo, prev_sdo);
            if (ee_cs && !prev_cs) begin
                chk(cslo_run >= HALF, "R4", "select low gap", cslo_run, HALF);
                nbits = 0; fval = '0; rd_mode = 0; cs_hi_cyc = 0;
            end
            if (ee_sck && !prev_sck) begin
                chk(lo_run == HALF, "R3", "clock low phase", lo_run, HALF);
                if (rd_mode) ee_sdi = mem[rd_addr][15 - (nbits - CB)];
                fval = {fval[30:0], ee_sdo};
                nbits++;
                if (nbits == CB && fval[CB-1:CB-3] == 3'b110) begin
                    rd_mode = 1; rd_addr = fval[AB-1:0];
                end
            end
            if (!ee_sck && prev_sck) begin
                chk(hi_run == HALF, "R3", "clock high phase", hi_run, HALF);
                last_fall = cyc;
            end
            if (!ee_cs && prev_cs) begin
                flen_q.push_back(nbits);
                fval_q.push_back(fval);
                if (nbits == 0) begin
                    poll_len_last = cs_hi_cyc;
                    pend = 0;
                end else if (nbits == CB && fval[CB-1:CB-3] == 3'b100) begin
                    if (fval[AB-1:AB-2] == 2'b11) wen = 1;
                    if (fval[AB-1:0] == '0) wen = 0;
                end else if (nbits == CB + 16 && fval[CB+15:CB+13] == 3'b101) begin
                    if (wen) mem[fval[AB+15:16]] = fval[15:0];
                    pend = 1;
                end
                rd_mode = 0;
                ee_sdi = 0;
            end
            if (ee_cs) begin
                cs_hi_cyc++;
                if (pend && nbits == 0) ee_sdi = (cs_hi_cyc >= ready_delay);
            end
            if (done) begin
                done_cnt++;
                chk(cyc - last_fall == HALF, "R10", "done delay after last fall", cyc - last_fall, HALF);
            end
            if (done && prev_done) chk(0, "R10", "done wider than one cycle", 2, 1);
            if (ee_cs && !ee_sck) lo_run++; else lo_run = 0;
            if (ee_sck) hi_run++; else hi_run = 0;
            if (!ee_cs) cslo_run++; else cslo_run = 0;
            prev_cs = ee_cs; prev_sck = ee_sck; prev_sdo = ee_sdo; prev_done = done;
        end
    end

    function automatic logic [31:0] cmd_of(logic [2:0] op, logic [7:0] a);
        return {21'd0, op, a};
    endfunction

    task automatic run_op(bit wr, logic [AB:0] off, logic [15:0] d, bit poke);
        int c0;
        c0 = done_cnt;
        flen_q.delete();
        fval_q.delete();
        @(negedge clk);
        start = 1; op_write = wr; byte_off = off; wdata = d;
        @(negedge clk);
        start = 0;
        if (poke) begin
            repeat (20) @(negedge clk);
            start = 1; op_write = 1; byte_off = 9'h040; wdata = 16'hDEAD;
            @(negedge clk);
            start = 0;
        end
        while (done_cnt == c0) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_frame(int idx, int len, logic [31:0] val, string req);
        if (idx >= flen_q.size()) begin
            chk(0, req, "frame missing", flen_q.size(), idx + 1);
        end else begin
            chk(flen_q[idx] == len, req, "frame length", flen_q[idx], len);
            chk(fval_q[idx] == val, req, "frame bits", fval_q[idx], val);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int c1;
        for (int i = 0; i < 256; i++) mem[i] = 16'(i * 16'h0101) ^ 16'h5A5A;
        mem[255] = 16'h8001;
        mem[0]   = 16'h0F0F;
        repeat (4) @(negedge clk);
        rst_n = 1;
        repeat (5) @(negedge clk);

        // R1 reset state
        chk({ee_cs, ee_sck, ee_sdo} == 3'b000, "R1", "serial lines after reset", {ee_cs, ee_sck, ee_sdo}, 0);
        chk(!done && !timeout, "R1", "flags after reset", {done, timeout}, 0);
        chk(rdata == 16'h0, "R1", "rdata after reset", rdata, 0);

        // Write with quick ready: R2 R6 R7 R9 R12
        ready_delay = 12;
        run_op(1, 9'h020, 16'hA5C3, 0);
        chk(flen_q.size() == 4, "R6", "write frame count", flen_q.size(), 4);
        chk_frame(0, CB, cmd_of(3'b100, 8'hC0), "R6");
        chk_frame(1, CB + 16, {cmd_of(3'b101, 8'h10), 16'h0} | 32'hA5C3, "R2");
        chk_frame(2, 0, 32'h0, "R7");
        chk_frame(3, CB, cmd_of(3'b100, 8'h00), "R9");
        chk(!timeout, "R7", "no timeout on ready", timeout, 0);
        chk(poll_len_last < MP * PC && poll_len_last >= ready_delay, "R7", "ready wait length", poll_len_last, 15);
        chk(rdata == 16'h0, "R12", "rdata after write", rdata, 0);
        chk({ee_cs, ee_sck, ee_sdo} == 3'b000, "R9", "lines released", {ee_cs, ee_sck, ee_sdo}, 0);

        // Read back: R5 R2
        run_op(0, 9'h020, 16'h0, 0);
        chk(flen_q.size() == 1, "R5", "read frame count", flen_q.size(), 1);
        chk_frame(0, CB + 16, {cmd_of(3'b110, 8'h10), 16'h0}, "R5");
        chk(rdata == 16'hA5C3, "R5", "read data", rdata, 16'hA5C3);

        // Top address, edge bit pattern: R2 R5
        run_op(0, 9'h1FE, 16'h0, 0);
        chk_frame(0, CB + 16, {cmd_of(3'b110, 8'hFF), 16'h0}, "R2");
        chk(rdata == 16'h8001, "R5", "read top word", rdata, 16'h8001);

        // Write that never becomes ready: R8 R9 R12
        ready_delay = 1000000;
        run_op(1, 9'h1FE, 16'h1234, 0);
        chk(timeout, "R8", "timeout flag", timeout, 1);
        chk(poll_len_last >= MP * PC && poll_len_last <= MP * PC + 1, "R8", "wait length", poll_len_last, MP * PC);
        chk(flen_q.size() == 4, "R9", "frame count after timeout", flen_q.size(), 4);
        chk_frame(3, CB, cmd_of(3'b100, 8'h00), "R9");
        chk(rdata == 16'h8001, "R12", "rdata unchanged by write", rdata, 16'h8001);
        chk({ee_cs, ee_sck, ee_sdo} == 3'b000, "R9", "lines released after timeout", {ee_cs, ee_sck, ee_sdo}, 0);
        repeat (10) @(negedge clk);
        chk(timeout, "R8", "timeout held while idle", timeout, 1);

        // Odd byte offset drops bit 0; start clears timeout: R2 R8
        ready_delay = 12;
        run_op(0, 9'h021, 16'h0, 0);
        chk_frame(0, CB + 16, {cmd_of(3'b110, 8'h10), 16'h0}, "R2");
        chk(rdata == 16'hA5C3, "R2", "odd offset read", rdata, 16'hA5C3);
        chk(!timeout, "R8", "timeout cleared by start", timeout, 0);

        // Start while busy is ignored: R11
        c1 = done_cnt;
        run_op(0, 9'h000, 16'h0, 1);
        repeat (80) @(negedge clk);
        chk(done_cnt == c1 + 1, "R11", "done count", done_cnt - c1, 1);
        chk(flen_q.size() == 1, "R11", "frames after busy start", flen_q.size(), 1);
        chk_frame(0, CB + 16, {cmd_of(3'b110, 8'h00), 16'h0}, "R11");
        chk(rdata == 16'h0F0F, "R11", "read unaffected", rdata, 16'h0F0F);

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule